// File: doc/BRIEF.md
# Nonlinear Transient Pulse Injector

This block sits beside the linear PWM path of a multiphase buck controller and reacts to large output-voltage excursions faster than the switching clock allows. It compares the digitized regulation error (output minus target) against three magnitudes: a shallow undershoot level, a deep undershoot level and an overshoot level. When an excursion is confirmed, it takes over the per-phase high-side PWM and low-side enable signals. It stops overriding once the error has stayed back inside the window long enough.

On an undershoot, a group of phases receives extra on-pulses right away. A deeper undershoot adds a second group, and all of its phases start together. Each pulse has a programmable minimum on-time and minimum off-time. A phase may start a pulse only while its own switching-synchronous counter is inside a slot window. On an overshoot, every high-side gate is held off and the low-side FETs follow one of three selectable braking behaviours. While no excursion is active, the linear PWM passes through with one register of latency.

Top module: `surge_injector`

## Requirements
- R1: While `rst` is high, `pwm_o` and `ls_o` are all zero, whatever values the linear inputs carry.
- R2: With no active excursion, `pwm_o` and `ls_o` equal `pwm_lin` and `ls_lin` as sampled one clock edge earlier.
- R3: An excursion takes effect only after two consecutive out-of-window error samples, so a single out-of-window sample has no effect. If the error is applied before edge n+1, the override state is entered at edge n+3. Release outputs change at edge n+4 and the first injected pulse appears at edge n+5.
- R4: Shallow engage: the error is strictly below minus `eng1_thr`. Each phase set in `lvl1_mask` drives `pwm_o` high for `on_min` cycles (0 counts as 1), and its `ls_o` is low during that time. Phases outside the active mask keep their linear values.
- R5: After an injected pulse ends, the same phase stays low for at least `off_min` cycles (0 counts as 1) before it can start another pulse.
- R6: Deep engage: the error is strictly below minus `eng2_thr`. It enables the phases in `lvl1_mask | lvl2_mask`, and newly enabled idle phases all start their pulse on the same edge. Deep engage outranks shallow engage and is kept until exit.
- R7: A phase starts a pulse only when its 8-bit field of `ph_cnt` (phase i at bits 8i+7..8i) is strictly less than `slot_len`.
- R8: Release: the error is strictly above `rel_thr`. All `pwm_o` are forced low. `ls_o` depends on `rel_mode`: 0 holds all ones, 1 follows the slot-gated pulse timer for every phase, and 2 or 3 holds all zeros (body brake).
- R9: Control returns to pass-through once the confirmed error has been in the window for `exit_len` consecutive cycles (0 counts as 1). Any new confirmed excursion restarts that count.
- R10: A confirmed engage condition during release switches the block to engage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | EW (12) | Signed regulation error, output minus target |
| eng1_thr | input | EW-1 | Shallow undershoot magnitude |
| eng2_thr | input | EW-1 | Deep undershoot magnitude |
| rel_thr | input | EW-1 | Overshoot magnitude |
| lvl1_mask | input | NPH (6) | Phases pulsed on shallow engage |
| lvl2_mask | input | NPH | Extra phases pulsed on deep engage |
| slot_len | input | CW (8) | Slot window length on the phase counters |
| ph_cnt | input | NPH*CW | Per-phase switching-synchronous counters |
| rel_mode | input | 2 | Release braking behaviour |
| on_min | input | TW (6) | Minimum injected on-time in cycles |
| off_min | input | TW | Minimum off-time between pulses in cycles |
| exit_len | input | TW | In-window cycles needed before hand-back |
| pwm_lin | input | NPH | Linear-loop high-side PWM per phase |
| ls_lin | input | NPH | Linear-loop low-side enable per phase |
| pwm_o | output | NPH | Final high-side PWM per phase |
| ls_o | output | NPH | Final low-side enable per phase |

## Verification
The bound checker watches several properties on every cycle:
- pass-through while idle,
- all high-side gates low during release,
- a zero low-side output under body brake,
- minimum on-time and minimum off-time per phase,
- no pulse starting outside its slot.

Other behaviours depend on timed sequences of error values, so only the bench scenarios show them:
- the two-sample confirmation and the rejection of a one-sample glitch,
- the exact edges where pulses begin,
- escalation to the deep level,
- the exit count and the hand-over from release to engage.

// File: rtl/surge_pkg.sv
package surge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ENG1 = 2'd1,
    ST_ENG2 = 2'd2,
    ST_REL  = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    REL_HOLD  = 2'd0,
    REL_MOD   = 2'd1,
    REL_BRAKE = 2'd2
  } rel_e;
endpackage

// File: rtl/surge_detect.sv
module surge_detect #(
  parameter int EW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err_i,
  input  logic [EW-2:0]        eng1_thr,
  input  logic [EW-2:0]        eng2_thr,
  input  logic [EW-2:0]        rel_thr,
  output logic                 e1_f,
  output logic                 e2_f,
  output logic                 rel_f
);
  localparam int NCMP = 3;

  logic signed [EW-1:0] lo1, lo2, hi;
  logic [NCMP-1:0] raw, smp;

  assign lo1 = -$signed({1'b0, eng1_thr});
  assign lo2 = -$signed({1'b0, eng2_thr});
  assign hi  =  $signed({1'b0, rel_thr});

  assign raw[0] = err_i < lo1;
  assign raw[1] = err_i < lo2;
  assign raw[2] = err_i > hi;

  // two-sample confirmation: a flag rises only if the previous sample agreed
  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= '0;
      e1_f  <= 1'b0;
      e2_f  <= 1'b0;
      rel_f <= 1'b0;
    end else begin
      smp   <= raw;
      e1_f  <= raw[0] & smp[0];
      e2_f  <= raw[1] & smp[1];
      rel_f <= raw[2] & smp[2];
    end
  end
endmodule

// File: rtl/surge_ctrl.sv
module surge_ctrl
  import surge_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          e1_f,
  input  logic          e2_f,
  input  logic          rel_f,
  input  logic [TW-1:0] exit_len,
  output st_e           st
);
  logic [TW-1:0] quiet;
  logic [TW:0]   quiet_nx;
  logic          any_f;

  assign any_f    = e1_f | e2_f | rel_f;
  assign quiet_nx = {1'b0, quiet} + {{TW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      quiet <= '0;
    end else begin
      if (any_f) quiet <= '0;
      if (e2_f) begin
        st <= ST_ENG2;
      end else if (e1_f && st != ST_ENG2) begin
        st <= ST_ENG1;
      end else if (rel_f) begin
        st <= ST_REL;
      end else if (!any_f && st != ST_IDLE) begin
        if (quiet_nx >= {1'b0, exit_len}) begin
          st    <= ST_IDLE;
          quiet <= '0;
        end else begin
          quiet <= quiet_nx[TW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/surge_pulse.sv
module surge_pulse #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [TW-1:0] on_min,
  input  logic [TW-1:0] off_min,
  output logic          pulse
);
  logic [TW-1:0] tmr, on_len, off_len;
  logic          on_q;

  assign on_len  = (on_min  == '0) ? '0 : on_min  - 1'b1;
  assign off_len = (off_min == '0) ? '0 : off_min - 1'b1;
  assign pulse   = on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q <= 1'b0;
      tmr  <= '0;
    end else if (on_q) begin
      if (tmr == '0) begin
        on_q <= 1'b0;
        tmr  <= off_len;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else if (fire) begin
      on_q <= 1'b1;
      tmr  <= on_len;
    end
  end
endmodule

// File: rtl/surge_injector.sv
module surge_injector
  import surge_pkg::*;
#(
  parameter int NPH = 6,
  parameter int EW  = 12,
  parameter int CW  = 8,
  parameter int TW  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err_i,
  input  logic [EW-2:0]        eng1_thr,
  input  logic [EW-2:0]        eng2_thr,
  input  logic [EW-2:0]        rel_thr,
  input  logic [NPH-1:0]       lvl1_mask,
  input  logic [NPH-1:0]       lvl2_mask,
  input  logic [CW-1:0]        slot_len,
  input  logic [NPH*CW-1:0]    ph_cnt,
  input  logic [1:0]           rel_mode,
  input  logic [TW-1:0]        on_min,
  input  logic [TW-1:0]        off_min,
  input  logic [TW-1:0]        exit_len,
  input  logic [NPH-1:0]       pwm_lin,
  input  logic [NPH-1:0]       ls_lin,
  output logic [NPH-1:0]       pwm_o,
  output logic [NPH-1:0]       ls_o
);
  logic e1_f, e2_f, rel_f;
  st_e  st;
  logic [NPH-1:0] slot_ok, en, fire, pulse_v;

  surge_detect #(.EW(EW)) u_det (
    .clk(clk), .rst(rst), .err_i(err_i),
    .eng1_thr(eng1_thr), .eng2_thr(eng2_thr), .rel_thr(rel_thr),
    .e1_f(e1_f), .e2_f(e2_f), .rel_f(rel_f)
  );

  surge_ctrl #(.TW(TW)) u_ctl (
    .clk(clk), .rst(rst), .e1_f(e1_f), .e2_f(e2_f), .rel_f(rel_f),
    .exit_len(exit_len), .st(st)
  );

  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      unique case (st)
        ST_ENG1: en[i] = lvl1_mask[i];
        ST_ENG2: en[i] = lvl1_mask[i] | lvl2_mask[i];
        ST_REL:  en[i] = (rel_mode == REL_MOD);
        default: en[i] = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    assign slot_ok[g] = ph_cnt[g*CW +: CW] < slot_len;
    assign fire[g]    = en[g] & slot_ok[g];
    surge_pulse #(.TW(TW)) u_pg (
      .clk(clk), .rst(rst), .fire(fire[g]),
      .on_min(on_min), .off_min(off_min), .pulse(pulse_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o <= '0;
      ls_o  <= '0;
    end else begin
      unique case (st)
        ST_ENG1, ST_ENG2: begin
          pwm_o <= pwm_lin | (pulse_v & en);
          ls_o  <= ls_lin & ~(pulse_v & en);
        end
        ST_REL: begin
          pwm_o <= '0;
          case (rel_mode)
            REL_HOLD: ls_o <= '1;
            REL_MOD:  ls_o <= pulse_v;
            default:  ls_o <= '0;
          endcase
        end
        default: begin
          pwm_o <= pwm_lin;
          ls_o  <= ls_lin;
        end
      endcase
    end
  end
endmodule

// File: rtl/surge_chk.sv
module surge_chk
  import surge_pkg::*;
#(
  parameter int NPH = 6,
  parameter int CW  = 8,
  parameter int TW  = 6
) (
  input logic              clk,
  input logic              rst,
  input st_e               st,
  input logic [NPH-1:0]    pulse_v,
  input logic [NPH-1:0]    pwm_lin,
  input logic [NPH-1:0]    ls_lin,
  input logic [NPH-1:0]    pwm_o,
  input logic [NPH-1:0]    ls_o,
  input logic [1:0]        rel_mode,
  input logic [TW-1:0]     on_min,
  input logic [TW-1:0]     off_min,
  input logic [CW-1:0]     slot_len,
  input logic [NPH*CW-1:0] ph_cnt
);
  // R2: pass-through while idle
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |=> (pwm_o == $past(pwm_lin) && ls_o == $past(ls_lin)));

  // R8: high side off in release
  p_rel_hs_off_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL) |=> (pwm_o == '0));

  // R8: body brake leaves low side off
  p_brake_ls_off_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL && rel_mode[1]) |=> (ls_o == '0));

  for (genvar g = 0; g < NPH; g++) begin : g_chk
    // R4: minimum on-time
    p_min_on_r4: assert property (@(posedge clk) disable iff (rst)
      ($rose(pulse_v[g]) && on_min >= 2) |=> pulse_v[g]);
    // R5: minimum off-time
    p_min_off_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(pulse_v[g]) && off_min >= 2) |=> !pulse_v[g]);
    // R7: pulses start only inside the slot
    p_slot_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_v[g]) |-> $past(ph_cnt[g*CW +: CW] < slot_len));
  end
endmodule

bind surge_injector surge_chk #(.NPH(NPH), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .st(st), .pulse_v(pulse_v),
  .pwm_lin(pwm_lin), .ls_lin(ls_lin), .pwm_o(pwm_o), .ls_o(ls_o),
  .rel_mode(rel_mode), .on_min(on_min), .off_min(off_min),
  .slot_len(slot_len), .ph_cnt(ph_cnt)
);

// File: tb/surge_injector_bench.sv
`timescale 1ns/1ps
module surge_injector_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] err_i;
  logic [10:0] eng1_thr, eng2_thr, rel_thr;
  logic [5:0]  lvl1_mask, lvl2_mask, pwm_lin, ls_lin, pwm_o, ls_o;
  logic [7:0]  slot_len;
  logic [47:0] ph_cnt;
  logic [1:0]  rel_mode;
  logic [5:0]  on_min, off_min, exit_len;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int cyc;
    logic [5:0] p, pm, l, lm;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  surge_injector u_surge_injector (
    .clk(clk), .rst(rst), .err_i(err_i),
    .eng1_thr(eng1_thr), .eng2_thr(eng2_thr), .rel_thr(rel_thr),
    .lvl1_mask(lvl1_mask), .lvl2_mask(lvl2_mask), .slot_len(slot_len),
    .ph_cnt(ph_cnt), .rel_mode(rel_mode), .on_min(on_min),
    .off_min(off_min), .exit_len(exit_len), .pwm_lin(pwm_lin),
    .ls_lin(ls_lin), .pwm_o(pwm_o), .ls_o(ls_o)
  );

  task automatic expect_at(input int at, input logic [5:0] p, input logic [5:0] pm,
                           input logic [5:0] l, input logic [5:0] lm, input string tag);
    exp_t e;
    e.cyc = at; e.p = p; e.pm = pm; e.l = l; e.lm = lm; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare expected items when their cycle comes up
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].cyc == cyc) begin
        total++;
        if (((pwm_o & sb[k].pm) != (sb[k].p & sb[k].pm)) ||
            ((ls_o & sb[k].lm) != (sb[k].l & sb[k].lm))) begin
          bad++;
          $display("FAIL %s cyc=%0d actual pwm=%b ls=%b expected pwm=%b ls=%b (masks %b %b)",
                   sb[k].tag, cyc, pwm_o, ls_o, sb[k].p, sb[k].l, sb[k].pm, sb[k].lm);
        end
        sb.delete(k);
      end else if (sb[k].cyc < cyc) begin
        total++; bad++;
        $display("FAIL %s missed cyc=%0d actual=none expected=sampled", sb[k].tag, sb[k].cyc);
        sb.delete(k);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    err_i = '0; eng1_thr = 11'd20; eng2_thr = 11'd60; rel_thr = 11'd25;
    lvl1_mask = 6'b000011; lvl2_mask = 6'b111100; slot_len = 8'd200;
    ph_cnt = '0; rel_mode = 2'd0; on_min = 6'd3; off_min = 6'd2; exit_len = 6'd4;
    pwm_lin = 6'b101010; ls_lin = 6'b010101;

    // R1: reset state
    @(negedge clk); c = cyc;
    expect_at(c + 1, 6'h00, 6'h3f, 6'h00, 6'h3f, "R1 reset");
    idle(3);
    rst = 1'b0;

    // R2: pass-through
    @(negedge clk); pwm_lin = 6'b110001; ls_lin = 6'b001110; c = cyc;
    expect_at(c + 1, 6'b110001, 6'h3f, 6'b001110, 6'h3f, "R2 pass a");
    @(negedge clk); pwm_lin = 6'b000111; ls_lin = 6'b111000;
    expect_at(c + 2, 6'b000111, 6'h3f, 6'b111000, 6'h3f, "R2 pass b");
    @(negedge clk); pwm_lin = 6'h00; ls_lin = 6'h3f;
    idle(3);

    // R3: single-sample glitch ignored
    @(negedge clk); err_i = -12'sd30; c = cyc;
    @(negedge clk); err_i = '0;
    for (int k = 1; k <= 8; k++)
      expect_at(c + k, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R3 glitch");
    idle(10);

    // R4/R5: shallow engage pulses, latency, gap
    @(negedge clk); err_i = -12'sd30; c = cyc;
    expect_at(c + 4, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R3 no early pulse");
    for (int k = 5; k <= 7; k++)
      expect_at(c + k, 6'b000011, 6'h3f, 6'b111100, 6'h3f, "R4 on pulse");
    expect_at(c + 8, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R5 gap a");
    expect_at(c + 9, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R5 gap b");
    expect_at(c + 10, 6'b000011, 6'h3f, 6'b111100, 6'h3f, "R5 next pulse");
    idle(11);

    // R6: deep engage adds phases 2..5 at once
    err_i = -12'sd80; c = cyc;
    expect_at(c + 4, 6'h00, 6'b111100, 6'b111100, 6'b111100, "R6 not yet");
    expect_at(c + 5, 6'b111100, 6'b111100, 6'h00, 6'b111100, "R6 deep pulse");
    idle(6);
    err_i = '0;
    idle(30);

    // R8 hold mode, R3 latency, R9 exit
    pwm_lin = 6'h3f; ls_lin = 6'h00; rel_mode = 2'd0;
    err_i = 12'sd40; c = cyc;
    expect_at(c + 3, 6'h3f, 6'h3f, 6'h00, 6'h3f, "R3 release latency");
    expect_at(c + 4, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R8 hold ls");
    idle(6);
    err_i = '0; c = cyc;
    expect_at(c + 5, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R9 still held");
    expect_at(c + 6, 6'h3f, 6'h3f, 6'h00, 6'h3f, "R9 handed back");
    idle(12);

    // R10: engage during release
    pwm_lin = 6'h00; ls_lin = 6'h00;
    err_i = 12'sd40;
    idle(6);
    err_i = -12'sd30; c = cyc;
    expect_at(c + 4, 6'h00, 6'h3f, 6'h00, 6'h3f, "R10 left release");
    expect_at(c + 5, 6'b000011, 6'h3f, 6'h00, 6'h3f, "R10 engage pulse");
    idle(8);
    err_i = '0;
    idle(20);

    // R8 body brake
    pwm_lin = 6'h3f; ls_lin = 6'h3f; rel_mode = 2'd2;
    err_i = 12'sd40; c = cyc;
    expect_at(c + 4, 6'h00, 6'h3f, 6'h00, 6'h3f, "R8 brake");
    idle(6);
    err_i = '0;
    idle(20);

    // R8 modulated low side
    rel_mode = 2'd1;
    err_i = 12'sd40; c = cyc;
    expect_at(c + 4, 6'h00, 6'h3f, 6'h00, 6'h3f, "R8 mod start");
    for (int k = 5; k <= 7; k++)
      expect_at(c + k, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R8 mod on");
    expect_at(c + 8, 6'h00, 6'h3f, 6'h00, 6'h3f, "R8 mod off");
    expect_at(c + 10, 6'h00, 6'h3f, 6'h3f, 6'h3f, "R8 mod again");
    idle(12);
    err_i = '0;
    idle(20);

    // R7: slot gating (phase0 at slot_len, phase1 at slot_len-1)
    rel_mode = 2'd0; pwm_lin = 6'h00; ls_lin = 6'h00; slot_len = 8'd10;
    ph_cnt = {32'd0, 8'd9, 8'd10};
    err_i = -12'sd30; c = cyc;
    for (int k = 5; k <= 7; k++)
      expect_at(c + k, 6'b000010, 6'b000011, 6'h00, 6'h00, "R7 slot gate");
    idle(8);
    ph_cnt[7:0] = 8'd3;
    expect_at(c + 10, 6'b000001, 6'b000001, 6'h00, 6'h00, "R7 slot open");
    idle(4);
    err_i = '0;
    idle(20);

    wait (sb.size() == 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule